// File: doc/BRIEF.md
# Programmable RAM Access Timing Sequencer

This block issues single read accesses to two synchronous RAMs, a tag RAM and a data RAM. The timing of each RAM is set by software through control inputs. A caller presents a request on a valid/ready handshake. A select bit picks the RAM, and an address comes with it. The sequencer then runs the access with that RAM's own timing. An optional setup cycle comes first. In that cycle the address is already on the RAM pins but the enable stays low. Next the enable pulses for one cycle. The read data is then taken a programmed number of cycles later, and a response-valid strobe marks that cycle.

The latency codes do not map linearly to cycles. For the tag RAM, the two lowest codes share the minimum wait, and every code with its top bit set gives the same maximum wait. For the data RAM, the two lowest codes share the minimum wait and each higher code adds one cycle. The timing codes, the select bit and the address are all captured when a request is accepted. A change to them while the access is running has no effect. Only one access is in flight at a time.

Top module: `ram_timing_seq`

## Requirements
- R1: `req_ready` is high while idle. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance up to and including the response cycle, and it is high again in the cycle after the response.
- R2: The tag latency code `tag_lat` decodes to these waits: codes 0 and 1 give 2 cycles, 2 gives 3, 3 gives 4, and 4 to 7 give 5.
- R3: The data latency code `dat_lat` decodes to these waits: codes 0 and 1 give 2 cycles, and each code from 2 to 7 gives its value plus one, so 7 gives 8.
- R4: When the selected RAM's setup bit (`tag_setup` or `dat_setup`) is 0, that RAM's enable is high in the first cycle after acceptance.
- R5: When the selected RAM's setup bit is 1, the first cycle after acceptance is a setup cycle. In it the selected address is driven and both enables are low. The enable is high in the following cycle.
- R6: Each access gives exactly one enable pulse, one cycle long, and only on the selected RAM (`req_sel` 0 selects tag, 1 selects data). The other RAM's enable stays low and its address output stays zero.
- R7: The selected RAM's address output holds the accepted address from the first cycle after acceptance through the response cycle. Both address outputs are zero while idle.
- R8: `rsp_valid` is high for exactly one cycle, the cycle numbered L when the enable cycle is numbered 1, where L is the decoded latency. In that cycle `rsp_data` equals the selected RAM's read data. In all other cycles `rsp_data` is zero.
- R9: The timing codes, setup bits, select and address are taken at acceptance. Changing them during an access does not alter that access.
- R10: While an access is in flight, `req_valid` has no effect. No second access starts until `req_ready` has returned high.
- R11: While reset is asserted (`rst_n` low), the block is idle: `req_ready` high, both enables low, both addresses zero, `rsp_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_sel | input | 1 | Target RAM: 0 tag, 1 data |
| req_addr | input | AW | Access address |
| tag_setup | input | 1 | Tag RAM setup cycle enable |
| tag_lat | input | 3 | Tag RAM latency code |
| dat_setup | input | 1 | Data RAM setup cycle enable |
| dat_lat | input | 3 | Data RAM latency code |
| tag_en | output | 1 | Tag RAM enable |
| tag_addr | output | AW | Tag RAM address |
| tag_rdata | input | DW | Tag RAM read data |
| dat_en | output | 1 | Data RAM enable |
| dat_addr | output | AW | Data RAM address |
| dat_rdata | input | DW | Data RAM read data |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | DW | Captured read data |

## Verification
All eight codes of each latency field are tried, each with the setup bit both clear and set. These runs separate the tag decode, with its folded top range, from the linear data decode, and they expose any off-by-one in the setup insertion or in the latency count. In the bench model the RAM read data changes on every clock. A capture taken even one cycle early or late therefore returns a different value. Further patterns cover several more cases. One changes the codes, select and address right after acceptance, to show they are latched. One keeps `req_valid` high through an access, to show that busy requests are ignored. Another sends back-to-back requests to alternating RAMs, to show ready returns on time and the enables do not leak to the other RAM.

// File: rtl/ram_timing_seq.sv
module ram_timing_seq #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_sel,
  input  logic [AW-1:0] req_addr,
  input  logic          tag_setup,
  input  logic [2:0]    tag_lat,
  input  logic          dat_setup,
  input  logic [2:0]    dat_lat,
  output logic          tag_en,
  output logic [AW-1:0] tag_addr,
  input  logic [DW-1:0] tag_rdata,
  output logic          dat_en,
  output logic [AW-1:0] dat_addr,
  input  logic [DW-1:0] dat_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  localparam int CW = 4;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACCESS} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lat_q;
  logic          sel_q;
  logic [AW-1:0] addr_q;

  function automatic logic [CW-1:0] tag_wait(input logic [2:0] code);
    if (code[2])      return CW'(5);
    else if (code[1]) return code[0] ? CW'(4) : CW'(3);
    else              return CW'(2);
  endfunction

  function automatic logic [CW-1:0] dat_wait(input logic [2:0] code);
    return (code < 3'd2) ? CW'(2) : CW'(code) + CW'(1);
  endfunction

  wire accept = req_valid && (state == S_IDLE);
  wire setup_sel = req_sel ? dat_setup : tag_setup;
  wire [CW-1:0] lat_sel = req_sel ? dat_wait(dat_lat) : tag_wait(tag_lat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      lat_q  <= CW'(2);
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          sel_q  <= req_sel;
          addr_q <= req_addr;
          lat_q  <= lat_sel;
          cnt    <= CW'(1);
          state  <= setup_sel ? S_SETUP : S_ACCESS;
        end
        S_SETUP: state <= S_ACCESS;
        S_ACCESS: begin
          if (cnt == lat_q) state <= S_IDLE;
          else              cnt   <= cnt + CW'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  wire busy  = (state != S_IDLE);
  wire en_go = (state == S_ACCESS) && (cnt == CW'(1));

  assign req_ready = !busy;
  assign tag_en    = en_go && !sel_q;
  assign dat_en    = en_go && sel_q;
  assign tag_addr  = (busy && !sel_q) ? addr_q : '0;
  assign dat_addr  = (busy && sel_q) ? addr_q : '0;
  assign rsp_valid = (state == S_ACCESS) && (cnt == lat_q);
  assign rsp_data  = rsp_valid ? (sel_q ? dat_rdata : tag_rdata) : '0;

endmodule

// File: rtl/ram_timing_seq_chk.sv
module ram_timing_seq_chk #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_sel,
  input logic          tag_setup,
  input logic          dat_setup,
  input logic          tag_en,
  input logic          dat_en,
  input logic [AW-1:0] tag_addr,
  input logic [AW-1:0] dat_addr,
  input logic          rsp_valid
);

  AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_en && dat_en)); // R6

  AST_RSP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R1

  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready); // R1

  AST_TAG_NO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_sel && !tag_setup) |=> tag_en); // R4

  AST_DAT_NO_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel && !dat_setup) |=> dat_en); // R4

  AST_TAG_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_sel && tag_setup) |=> (!tag_en && !dat_en) ##1 tag_en); // R5

  AST_DAT_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_sel && dat_setup) |=> (!tag_en && !dat_en) ##1 dat_en); // R5

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !rsp_valid) |=> ($stable(tag_addr) && $stable(dat_addr))); // R7

  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (tag_addr == '0 && dat_addr == '0 && !tag_en && !dat_en)); // R7

endmodule

bind ram_timing_seq ram_timing_seq_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/ram_timing_seq_test.sv
`timescale 1ns/1ps
module ram_timing_seq_test;
  localparam int AW = 10;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_sel = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic tag_setup = 1'b0, dat_setup = 1'b0;
  logic [2:0] tag_lat = 3'd0, dat_lat = 3'd0;
  logic req_ready, tag_en, dat_en, rsp_valid;
  logic [AW-1:0] tag_addr, dat_addr;
  logic [DW-1:0] tag_rdata, dat_rdata, rsp_data;
  logic [31:0] cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] ram_word(input logic which, input logic [AW-1:0] a, input logic [31:0] c);
    if (which) return (DW'(a) * 32'h0001_0003) ^ ~c;
    else       return (DW'(a) * 32'h9E37_79B1) ^ c;
  endfunction

  assign tag_rdata = ram_word(1'b0, tag_addr, cyc);
  assign dat_rdata = ram_word(1'b1, dat_addr, cyc);

  ram_timing_seq #(.AW(AW), .DW(DW)) uut (.*);

  int n_checks = 0, n_fail = 0;

  bit m_busy = 0;
  int m_k = 0, m_s = 0, m_l = 2;
  bit m_sel = 0;
  logic [AW-1:0] m_addr = '0;

  function automatic int tag_cycles(input logic [2:0] c);
    if (c >= 3'd4) return 5;
    if (c <= 3'd1) return 2;
    return int'(c) + 1;
  endfunction

  function automatic int dat_cycles(input logic [2:0] c);
    if (c <= 3'd1) return 2;
    return int'(c) + 1;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  task automatic step();
    logic e_en;
    logic e_rsp;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_data;
    #2;
    e_en = m_busy && (m_k == m_s + 1);
    e_rsp = m_busy && (m_k == m_s + m_l);
    e_addr = m_busy ? m_addr : '0;
    e_data = e_rsp ? ram_word(m_sel, m_addr, cyc) : '0;
    chk("R1", "req_ready", 64'(req_ready), 64'(!m_busy));
    chk(m_s != 0 ? "R5" : "R4", "tag_en", 64'(tag_en), 64'(e_en && !m_sel));
    chk("R6", "dat_en", 64'(dat_en), 64'(e_en && m_sel));
    chk("R7", "tag_addr", 64'(tag_addr), 64'(m_sel ? '0 : e_addr));
    chk("R7", "dat_addr", 64'(dat_addr), 64'(m_sel ? e_addr : '0));
    chk(m_sel ? "R3" : "R2", "rsp_valid", 64'(rsp_valid), 64'(e_rsp));
    chk("R8", "rsp_data", 64'(rsp_data), 64'(e_data));
    if (m_busy) begin
      if (m_k == m_s + m_l) m_busy = 0;
      else m_k++;
    end else if (req_valid) begin
      m_busy = 1; m_k = 1; m_sel = req_sel; m_addr = req_addr;
      m_s = req_sel ? int'(dat_setup) : int'(tag_setup);
      m_l = req_sel ? dat_cycles(dat_lat) : tag_cycles(tag_lat);
    end
    @(negedge clk);
  endtask

  // keep: hold req_valid during the access (R10); scramble: change codes after acceptance (R9)
  task automatic issue(input logic sel, input logic [AW-1:0] a, input logic ts, input logic [2:0] tl,
                       input logic ds, input logic [2:0] dl, input bit keep, input bit scramble);
    bit acc;
    req_sel = sel; req_addr = a; tag_setup = ts; tag_lat = tl; dat_setup = ds; dat_lat = dl;
    req_valid = 1'b1;
    do begin acc = !m_busy; step(); end while (!acc);
    req_valid = keep;
    if (scramble) begin
      req_sel = ~sel; req_addr = ~a; tag_setup = ~ts; tag_lat = ~tl; dat_setup = ~ds; dat_lat = ~dl;
    end
    while (m_busy) step();
    req_valid = 1'b0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    #2;
    chk("R11", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R11", "reset enables", 64'({tag_en, dat_en}), 64'd0);
    chk("R11", "reset addresses", 64'({tag_addr, dat_addr}), 64'd0);
    chk("R11", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    step();
    // R2: every tag code, both setup settings
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++)
        issue(1'b0, AW'(37 * c + s + 3), s[0], c[2:0], 1'b0, 3'd0, 1'b0, 1'b0);
    // R3: every data code, both setup settings
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 8; c++)
        issue(1'b1, AW'(91 * c + s + 5), 1'b0, 3'd0, s[0], c[2:0], 1'b0, 1'b0);
    // R9: inputs scrambled right after acceptance
    issue(1'b0, AW'(10'h155), 1'b1, 3'd7, 1'b0, 3'd0, 1'b0, 1'b1);
    issue(1'b1, AW'(10'h2AA), 1'b0, 3'd0, 1'b1, 3'd7, 1'b0, 1'b1);
    issue(1'b0, AW'(10'h0F0), 1'b0, 3'd0, 1'b1, 3'd6, 1'b0, 1'b1);
    // R10: valid held through the access
    issue(1'b1, AW'(10'h3C3), 1'b1, 3'd2, 1'b0, 3'd4, 1'b1, 1'b0);
    issue(1'b0, AW'(10'h111), 1'b0, 3'd3, 1'b1, 3'd1, 1'b1, 1'b1);
    // R1 R6: back-to-back alternating RAMs
    for (int i = 0; i < 6; i++)
      issue(i[0], AW'(i * 53 + 1), i[1], 3'(i), ~i[1], 3'(7 - i), 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule